// File: doc/BRIEF.md
# Shared Interrupt Router for Four Cores

This block takes a set of shared, level-sensitive interrupt lines and delivers each one to a core. Every shared line has its own settings: a core bit mask naming the eligible destinations, a delivery mode, and a mask bit that silences the line. Software programs these settings through a simple one-cycle command port that carries an opcode, a line number and a data word. A single global switch gates all delivery.

In fixed mode a line goes to one core, the lowest-numbered core set in its destination mask. In rotating mode, each new assertion of a line goes to the next eligible core in circular order. A request held high stays with the core that received it, so a level-held request is never split or moved. The outputs form a grid of core by line. Bit `[c][i]` is shared line `i` as seen by core `c`, and line `i` lands on core-local interrupt number 24+i.

Top module: `cidu_top`

## Requirements
- R1: After reset the unit is disabled, every line is masked and every destination mask is zero, so no output is high even when inputs are asserted.
- R2: Opcode 1 writes the global enable from data bit 0. While the unit is disabled, every output is low, and clearing the enable drops outputs that are already high.
- R3: Opcode 2 writes the destination mask of the addressed line from data bits [NUM_CORES-1:0]. A line is only ever delivered to a core set in its mask.
- R4: Opcode 4 writes the addressed line's mask bit from data bit 0, where 1 silences the line and 0 lets it through. A masked line drives no output.
- R5: Opcode 3 writes the addressed line's mode from data bits [1:0], where 0 selects rotating delivery and 1, 2 or 3 select fixed delivery. All other data bits, including bit 4, have no effect.
- R6: In fixed mode an asserted line is delivered to the lowest-numbered core set in its destination mask.
- R7: In rotating mode an asserted line goes to the first core set in the mask at or after the line's pointer, searching circularly. The pointer is 0 after reset.
- R8: In rotating mode the chosen core keeps the line for as long as delivery continues. When delivery ends, because the input drops or the line stops being forwarded, the pointer moves to the core after that one.
- R9: A line whose destination mask is zero drives no output.
- R10: Outputs are registered. A change on an input or a setting shows at the outputs after one rising clock edge.
- R11: Commands whose line number is NUM_IRQS or above change nothing. Opcodes 0, 5, 6 and 7 change nothing.
- R12: At most one core receives a given line at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command opcode |
| cmd_idx_i | input | IDX_W | Shared line number addressed by the command |
| cmd_data_i | input | DATA_W | Command data word |
| irq_i | input | NUM_IRQS | Shared level-sensitive interrupt inputs |
| core_irq_o | output | NUM_CORES x NUM_IRQS | Per-core, per-line interrupt outputs |

## Verification
A corrupted rotation pointer or owner register shows at the ports on the next assertion of that line: the request lands on the wrong core, or it jumps between cores while the input is held. A wrong mask, enable or destination setting shows one edge after the input rises, as a stray or missing output bit. The directed pulse-and-hold sequences are chosen so that each of these mistakes moves the delivered core within one or two assertions.

// File: rtl/cidu_pkg.sv
package cidu_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_ENABLE = 3'd1,
        OP_DEST   = 3'd2,
        OP_MODE   = 3'd3,
        OP_MASK   = 3'd4
    } cidu_op_e;

    localparam logic [1:0] MODE_ROTATE = 2'd0;
endpackage

// File: rtl/cidu_cfg_regs.sv
module cidu_cfg_regs #(
    parameter int NI     = 8,
    parameter int NC     = 4,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cmd_valid_i,
    input  logic [2:0]               cmd_op_i,
    input  logic [IDX_W-1:0]         cmd_idx_i,
    input  logic [DATA_W-1:0]        cmd_data_i,
    output logic                     enable_o,
    output logic [NI-1:0]            mask_o,
    output logic [NI-1:0][NC-1:0]    dest_o,
    output logic [NI-1:0][1:0]       mode_o
);
    import cidu_pkg::*;

    localparam int IW = (NI > 1) ? $clog2(NI) : 1;

    typedef struct packed {
        logic                  en;
        logic [NI-1:0]         mask;
        logic [NI-1:0][NC-1:0] dest;
        logic [NI-1:0][1:0]    mode;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    cidu_op_e op;
    logic     in_range;
    logic     unused_data;

    assign op          = cidu_op_e'(cmd_op_i);
    assign in_range    = (int'(cmd_idx_i) < NI);
    assign unused_data = ^cmd_data_i[DATA_W-1:NC];

    always_comb begin
        cfg_d = cfg_q;
        if (cmd_valid_i) begin
            case (op)
                OP_ENABLE: cfg_d.en = cmd_data_i[0];
                OP_DEST: if (in_range) cfg_d.dest[cmd_idx_i[IW-1:0]] = cmd_data_i[NC-1:0];
                OP_MODE: if (in_range) cfg_d.mode[cmd_idx_i[IW-1:0]] = cmd_data_i[1:0];
                OP_MASK: if (in_range) cfg_d.mask[cmd_idx_i[IW-1:0]] = cmd_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.en   <= 1'b0;
            cfg_q.mask <= '1;
            cfg_q.dest <= '0;
            cfg_q.mode <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_o = cfg_q.en;
    assign mask_o   = cfg_q.mask;
    assign dest_o   = cfg_q.dest;
    assign mode_o   = cfg_q.mode;
endmodule

// File: rtl/cidu_route.sv
module cidu_route #(
    parameter int NC = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          irq_i,
    input  logic          enable_i,
    input  logic          mask_i,
    input  logic [NC-1:0] dest_i,
    input  logic [1:0]    mode_i,
    output logic [NC-1:0] lines_o
);
    import cidu_pkg::*;

    localparam int CW = (NC > 1) ? $clog2(NC) : 1;

    typedef struct packed {
        logic [CW-1:0] ptr;
        logic [CW-1:0] owner;
        logic          busy;
        logic [NC-1:0] lines;
    } rt_t;

    rt_t           rt_d, rt_q;
    logic          rotate, live, found;
    logic [CW-1:0] fix_core, rot_core, target;

    always_comb begin
        int j;
        rotate   = (mode_i == MODE_ROTATE);
        live     = irq_i & enable_i & ~mask_i & (|dest_i);

        fix_core = '0;
        for (int c = NC - 1; c >= 0; c--) begin
            if (dest_i[c]) fix_core = CW'(c);
        end

        found    = 1'b0;
        rot_core = rt_q.ptr;
        for (int k = 0; k < NC; k++) begin
            j = int'(rt_q.ptr) + k;
            if (j >= NC) j = j - NC;
            if (!found && dest_i[j]) begin
                rot_core = CW'(j);
                found    = 1'b1;
            end
        end

        target = rotate ? rot_core : fix_core;

        rt_d       = rt_q;
        rt_d.lines = live ? (NC'(1) << target) : '0;
        rt_d.busy  = live & rotate;
        if (live && rotate) rt_d.owner = target;
        if (rt_q.busy && !(live && rotate)) begin
            rt_d.ptr = (int'(rt_q.owner) == NC - 1) ? '0 : rt_q.owner + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rt_q <= '0;
        else         rt_q <= rt_d;
    end

    assign lines_o = rt_q.lines;
endmodule

// File: rtl/cidu_top.sv
module cidu_top #(
    parameter int NUM_IRQS  = 8,
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 8,
    parameter int DATA_W    = 32
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               cmd_valid_i,
    input  logic [2:0]                         cmd_op_i,
    input  logic [IDX_W-1:0]                   cmd_idx_i,
    input  logic [DATA_W-1:0]                  cmd_data_i,
    input  logic [NUM_IRQS-1:0]                irq_i,
    output logic [NUM_CORES-1:0][NUM_IRQS-1:0] core_irq_o
);
    logic                                en_w;
    logic [NUM_IRQS-1:0]                 mask_w;
    logic [NUM_IRQS-1:0][NUM_CORES-1:0]  dest_w;
    logic [NUM_IRQS-1:0][1:0]            mode_w;
    logic [NUM_IRQS-1:0][NUM_CORES-1:0]  col_w;

    cidu_cfg_regs #(
        .NI(NUM_IRQS), .NC(NUM_CORES), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_idx_i(cmd_idx_i), .cmd_data_i(cmd_data_i),
        .enable_o(en_w), .mask_o(mask_w), .dest_o(dest_w), .mode_o(mode_w)
    );

    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_line
        cidu_route #(.NC(NUM_CORES)) u_route (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .irq_i(irq_i[i]), .enable_i(en_w), .mask_i(mask_w[i]),
            .dest_i(dest_w[i]), .mode_i(mode_w[i]),
            .lines_o(col_w[i])
        );
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign core_irq_o[c][i] = col_w[i][c];
        end
    end
endmodule

// File: rtl/cidu_checker.sv
module cidu_checker #(
    parameter int NI = 8,
    parameter int NC = 4
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  en_i,
    input logic [NI-1:0]         mask_i,
    input logic [NI-1:0][NC-1:0] dest_i,
    input logic [NC-1:0][NI-1:0] lines_i
);
    logic [NI-1:0][NC-1:0] col;

    always_comb begin
        for (int i = 0; i < NI; i++)
            for (int c = 0; c < NC; c++)
                col[i][c] = lines_i[c][i];
    end

    a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i) |-> (lines_i == '0));

    for (genvar i = 0; i < NI; i++) begin : g_chk
        a_r12_single_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0(col[i]));
        a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(mask_i[i]) |-> (col[i] == '0));
        a_r9_no_dest_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(dest_i[i]) == '0) |-> (col[i] == '0));
        a_r3_within_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (col[i] & ~$past(dest_i[i])) == '0);
    end
endmodule

bind cidu_top cidu_checker #(.NI(NUM_IRQS), .NC(NUM_CORES)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w),
    .mask_i(mask_w), .dest_i(dest_w), .lines_i(core_irq_o)
);

// File: tb/cidu_top_test.sv
module cidu_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 8;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [7:0]        cmd_idx = '0;
    logic [31:0]       cmd_data = '0;
    logic [NI-1:0]     irq = '0;
    logic [NC-1:0][NI-1:0] core_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cidu_top uut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_idx_i(cmd_idx), .cmd_data_i(cmd_data), .irq_i(irq), .core_irq_o(core_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [NC-1:0] col(int i);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = core_irq[c][i];
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cmd(int op, int idx, logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = 8'(idx); cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0; cmd_data = '0;
    endtask

    task automatic pulse(int i, string tag, logic [NC-1:0] exp);
        irq[i] = 1'b1;
        @(negedge clk);
        chk(tag, 32'(col(i)), 32'(exp));
        irq[i] = 1'b0;
        @(negedge clk);
        chk({tag, " release"}, 32'(col(i)), 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", 32'(core_irq), 32'h0);
        irq = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 inputs ignored after reset", 32'(core_irq), 32'h0);
        irq = '0;
        @(negedge clk);
    endtask

    task automatic t_enable();
        cmd(2, 0, 32'h1); cmd(3, 0, 32'h1); cmd(4, 0, 32'h0);
        irq[0] = 1'b1;
        @(negedge clk);
        chk("R2 disabled unit quiet", 32'(col(0)), 32'h0);
        cmd(1, 0, 32'h1);
        @(negedge clk);
        chk("R2 enabled delivers", 32'(col(0)), 32'h1);
        cmd(1, 0, 32'h0);
        @(negedge clk);
        chk("R2 disable drops output", 32'(col(0)), 32'h0);
        irq[0] = 1'b0;
        cmd(1, 0, 32'h1);
    endtask

    task automatic t_fixed();
        cmd(2, 5, 32'h6); cmd(3, 5, 32'h1); cmd(4, 5, 32'h0);
        irq[5] = 1'b1;
        #1;
        chk("R10 no output before edge", 32'(col(5)), 32'h0);
        @(negedge clk);
        chk("R6 fixed lowest core", 32'(col(5)), 32'h2);
        irq[5] = 1'b0;
        @(negedge clk);
        pulse(5, "R6 fixed repeat same core", 4'h2);
        cmd(3, 5, 32'h13);
        pulse(5, "R5 mode 3 acts fixed", 4'h2);
        cmd(2, 5, 32'h8);
        pulse(5, "R3 new destination", 4'h8);
    endtask

    task automatic t_mode_bits();
        cmd(2, 5, 32'h6);
        cmd(3, 5, 32'hF0);
        pulse(5, "R5 upper bits ignored, rotate first", 4'h2);
        pulse(5, "R5 rotate second", 4'h4);
    endtask

    task automatic t_rotate();
        cmd(2, 2, 32'hB); cmd(3, 2, 32'h0); cmd(4, 2, 32'h0);
        pulse(2, "R7 starts at core 0", 4'h1);
        irq[2] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 held on core 1", 32'(col(2)), 32'h2);
            chk("R12 one core", 32'($countones(col(2))), 32'h1);
        end
        irq[2] = 1'b0;
        @(negedge clk);
        pulse(2, "R7 skips core 2", 4'h8);
        pulse(2, "R7 wraps to core 0", 4'h1);
    endtask

    task automatic t_mask();
        irq[2] = 1'b1;
        @(negedge clk);
        chk("R8 next core 1", 32'(col(2)), 32'h2);
        cmd(4, 2, 32'h1);
        @(negedge clk);
        chk("R4 masked line quiet", 32'(col(2)), 32'h0);
        cmd(4, 2, 32'h0);
        @(negedge clk);
        chk("R8 masking ended delivery, moved on", 32'(col(2)), 32'h8);
        irq[2] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero_dest();
        cmd(3, 7, 32'h1); cmd(4, 7, 32'h0);
        pulse(7, "R9 zero mask quiet", 4'h0);
    endtask

    task automatic t_range();
        cmd(4, 0, 32'h1);
        cmd(4, 8, 32'h0);
        cmd(2, 8, 32'h0);
        cmd(6, 0, 32'h0);
        pulse(0, "R11 out-of-range unmask ignored", 4'h0);
        cmd(4, 0, 32'h0);
        pulse(0, "R11 destination kept", 4'h1);
        cmd(0, 0, 32'h0);
        cmd(7, 0, 32'h0);
        pulse(0, "R11 spare opcodes ignored", 4'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_fixed();
        t_mode_bits();
        t_rotate();
        t_mask();
        t_zero_dest();
        t_range();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule